// File: doc/BRIEF.md
# Floating-point round-to-integral unit

This unit takes one IEEE-754 operand in half, single or double precision and returns the integral value nearest to it under a selected rounding direction. The result is in the same format as the operand. It is a floating-point value, not an integer. The unit raises an inexact flag whenever the rounded value differs numerically from the operand. It raises an invalid flag when it quiets a signalling NaN. Signed zeros and infinities pass through unchanged. A NaN can either be quieted in place or be replaced by the format's canonical quiet NaN.

All three formats are evaluated in parallel by one rounding core per format. A format select picks the core whose result is used. Result and flags are registered, so an operand presented at one clock edge is answered at the next edge. Narrow results sit in the low bits of the 64-bit result bus, and the bits above them are zero.

Top module: `fp_round_integral`

## Requirements
- R1: `fmt_i` selects the format: 00 half (operand bits 15:0), 01 single (bits 31:0), 10 double (bits 63:0). Every result bit above the selected width is zero. Code 11 yields a zero result with both flags clear.
- R2: `mode_i` selects the direction: 00 nearest, 01 toward +infinity, 10 toward -infinity, 11 toward zero. The result is the integral value of the operand's format chosen by that direction.
- R3: In nearest mode, a value exactly halfway between two integers rounds to the one whose least significant integer bit is zero.
- R4: `inexact_o` is set exactly when a finite, non-NaN result differs numerically from the operand.
- R5: A zero operand returns the same zero, sign included, with no flag.
- R6: An infinite operand returns the same infinity, sign included, with no flag.
- R7: An operand whose unbiased exponent is at least the fraction width (23 single, 52 double, 10 half) returns unchanged with no flag.
- R8: A nonzero operand of magnitude below one, subnormals included, returns a zero or a one carrying the operand's sign, and sets inexact. Negative values that round to zero give negative zero.
- R9: With `dnan_i` low, a NaN is returned with its top fraction bit forced to one. `invalid_o` is set only when that bit was zero on input (signalling NaN). A quiet NaN raises no flag.
- R10: With `dnan_i` high, any NaN returns the canonical quiet NaN: sign 0, exponent all ones, top fraction bit 1, other fraction bits 0. `invalid_o` still follows the signalling test of R9.
- R11: Outputs are registered. The answer to the inputs sampled at one rising edge appears after that edge. A synchronous active-high `rst` clears the result and both flags to zero.
- R12: `inexact_o` and `invalid_o` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 64 | Operand; narrow formats use the low bits |
| fmt_i | input | 2 | Format select |
| mode_i | input | 2 | Rounding direction |
| dnan_i | input | 1 | Replace NaN results by the canonical quiet NaN |
| res_o | output | 64 | Rounded integral value, zero-extended |
| inexact_o | output | 1 | Result differs from operand |
| invalid_o | output | 1 | Signalling NaN operand |

## Verification
The bench builds the block with its default 64-bit result bus. It drives half precision near-exhaustively: every 16-bit pattern is applied under two of the four rounding directions, so each direction sees half of all encodings. The expected value for each pattern is rebuilt from a scaled integer of the operand's value. This sweep brings every subnormal, tie, carry into the exponent and NaN payload of the narrow format within reach. Single and double precision share the same parameterised core. They are covered by directed operands at ties, below-one magnitudes, exponent boundaries and NaN kinds.

// File: rtl/fpri_pkg.sv
package fpri_pkg;
  typedef enum logic [1:0] {FMT_H = 2'b00, FMT_S = 2'b01, FMT_D = 2'b10, FMT_X = 2'b11} fmt_e;
  typedef enum logic [1:0] {RM_NE = 2'b00, RM_UP = 2'b01, RM_DN = 2'b10, RM_TZ = 2'b11} rmode_e;

  localparam int NFMT = 3;

  function automatic int fmt_exp_w(input int idx);
    case (idx)
      0: return 5;
      1: return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int idx);
    case (idx)
      0: return 10;
      1: return 23;
      default: return 52;
    endcase
  endfunction
endpackage

// File: rtl/fpri_core.sv
module fpri_core #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] op_i,
  input  logic [1:0]     mode_i,
  input  logic           dnan_i,
  output logic [EW+FW:0] res_o,
  output logic           inexact_o,
  output logic           invalid_o
);
  import fpri_pkg::*;

  localparam int W    = EW + FW + 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int SW   = $clog2(FW + 1) + 1;
  localparam logic [FW-1:0] ONES = {FW{1'b1}};

  logic            sgn;
  logic [EW-1:0]   ex;
  logic [FW-1:0]   fr;
  logic            ex_all1, ex_zero, fr_nz;
  logic [EW-1:0]   sh_full;
  logic [SW-1:0]   sh;
  logic [FW-1:0]   mask;
  logic            rbit, sticky, lsb, disc, up, to_one;
  logic [W-2:0]    mag_t, ulp;
  rmode_e          rm;

  assign sgn = op_i[W-1];
  assign ex  = op_i[W-2:FW];
  assign fr  = op_i[FW-1:0];
  assign rm  = rmode_e'(mode_i);

  always_comb begin
    ex_all1 = &ex;
    ex_zero = ~|ex;
    fr_nz   = |fr;
    sh_full = EW'(BIAS + FW) - ex;
    sh      = SW'(sh_full);
    mask    = ~(ONES << sh);
    rbit    = |(fr & (FW'(1) << (sh - SW'(1))));
    sticky  = |(fr & (mask >> 1));
    lsb     = (sh == SW'(FW)) | (|(fr & (FW'(1) << sh)));
    disc    = |(fr & mask);
    mag_t   = {ex, fr & ~mask};
    ulp     = (W-1)'(1) << sh;
    case (rm)
      RM_NE:   up = rbit & (sticky | lsb);
      RM_UP:   up = ~sgn & disc;
      RM_DN:   up = sgn & disc;
      default: up = 1'b0;
    endcase
    case (rm)
      RM_NE:   to_one = (ex == EW'(BIAS - 1)) & fr_nz;
      RM_UP:   to_one = ~sgn;
      RM_DN:   to_one = sgn;
      default: to_one = 1'b0;
    endcase

    res_o     = op_i;
    inexact_o = 1'b0;
    invalid_o = 1'b0;
    if (ex_all1) begin
      if (fr_nz) begin
        invalid_o = ~fr[FW-1];
        if (dnan_i) res_o = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
        else        res_o = {sgn, ex, 1'b1, fr[FW-2:0]};
      end
    end else if (ex_zero && !fr_nz) begin
      res_o = op_i;
    end else if (ex >= EW'(BIAS + FW)) begin
      res_o = op_i;
    end else if (ex < EW'(BIAS)) begin
      inexact_o = 1'b1;
      res_o     = to_one ? {sgn, EW'(BIAS), {FW{1'b0}}} : {sgn, {(W-1){1'b0}}};
    end else begin
      inexact_o = disc;
      res_o     = {sgn, up ? (mag_t + ulp) : mag_t};
    end
  end
endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] op_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    mode_i,
  input  logic          dnan_i,
  output logic [DW-1:0] res_o,
  output logic          inexact_o,
  output logic          invalid_o
);
  import fpri_pkg::*;

  logic [DW-1:0] res_ext [NFMT];
  logic          ix_v    [NFMT];
  logic          iv_v    [NFMT];
  fmt_e          fsel;

  assign fsel = fmt_e'(fmt_i);

  for (genvar i = 0; i < NFMT; i++) begin : g_fmt
    localparam int EW = fmt_exp_w(i);
    localparam int FW = fmt_frac_w(i);
    localparam int W  = EW + FW + 1;
    logic [W-1:0] r;
    fpri_core #(.EW(EW), .FW(FW)) u_core (
      .op_i      (op_i[W-1:0]),
      .mode_i    (mode_i),
      .dnan_i    (dnan_i),
      .res_o     (r),
      .inexact_o (ix_v[i]),
      .invalid_o (iv_v[i])
    );
    assign res_ext[i] = DW'(r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      case (fsel)
        FMT_H: begin res_o <= res_ext[0]; inexact_o <= ix_v[0]; invalid_o <= iv_v[0]; end
        FMT_S: begin res_o <= res_ext[1]; inexact_o <= ix_v[1]; invalid_o <= iv_v[1]; end
        FMT_D: begin res_o <= res_ext[2]; inexact_o <= ix_v[2]; invalid_o <= iv_v[2]; end
        default: begin res_o <= '0; inexact_o <= 1'b0; invalid_o <= 1'b0; end
      endcase
    end
  end

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !inexact_o && !invalid_o));
  p_flags_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(inexact_o && invalid_o));
  p_half_upper_r1: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == FMT_H) |=> (res_o[DW-1:16] == '0));
  p_bad_fmt_r1: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == FMT_X) |=> (res_o == '0 && !inexact_o && !invalid_o));
  p_inf_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == FMT_D && op_i[62:52] == 11'h7FF && op_i[51:0] == '0)
    |=> (res_o == $past(op_i) && !inexact_o && !invalid_o));
  p_integral_r7: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == FMT_D && op_i[62:52] != 11'h7FF && op_i[62:52] >= 11'd1075)
    |=> (res_o == $past(op_i) && !inexact_o));
  p_qnan_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (fmt_i == FMT_S && op_i[30:23] == 8'hFF && op_i[22] && !dnan_i)
    |=> (res_o == DW'($past(op_i[31:0])) && !inexact_o && !invalid_o));
endmodule

// File: tb/fp_round_integral_bench.sv
`timescale 1ns/1ps
module fp_round_integral_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op = '0;
  logic [1:0]  fmt = '0;
  logic [1:0]  mode = '0;
  logic        dn = 1'b0;
  logic [63:0] res;
  logic        ix, iv;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  fp_round_integral u_fp_round_integral (
    .clk(clk), .rst(rst), .op_i(op), .fmt_i(fmt), .mode_i(mode), .dnan_i(dn),
    .res_o(res), .inexact_o(ix), .invalid_o(iv)
  );

  // Returns {invalid, inexact, result} for a half-precision operand.
  function automatic logic [17:0] ref_half(input logic [15:0] x, input logic [1:0] m, input logic d);
    logic s; logic [4:0] e; logic [9:0] f;
    logic [63:0] val, q, rem, nv;
    logic upr; logic [15:0] r; int p;
    s = x[15]; e = x[14:10]; f = x[9:0];
    if (e == 5'h1F) begin
      if (f == 0) return {2'b00, x};
      r = d ? 16'h7E00 : (x | 16'h0200);
      return {~f[9], 1'b0, r};
    end
    val = (e == 0) ? 64'(f) : (64'(11'd1024 + 11'(f)) << (e - 1));
    q   = val >> 24;
    rem = val & 64'hFF_FFFF;
    case (m)
      2'b00: upr = (rem > 64'h80_0000) || (rem == 64'h80_0000 && q[0]);
      2'b01: upr = !s && rem != 0;
      2'b10: upr = s && rem != 0;
      default: upr = 1'b0;
    endcase
    nv = q + 64'(upr);
    if (nv == 0) r = {s, 15'h0};
    else begin
      p = 0;
      for (int b = 0; b < 20; b++) if (nv[b]) p = b;
      r[15] = s;
      r[14:10] = 5'(p + 15);
      r[9:0] = (p <= 10) ? 10'(nv << (10 - p)) : 10'(nv >> (p - 10));
    end
    return {1'b0, rem != 0, r};
  endfunction

  task automatic apply(input logic [1:0] f, input logic [63:0] x, input logic [1:0] m, input logic d);
    fmt = f; op = x; mode = m; dn = d;
    @(negedge clk);
  endtask

  task automatic check(input logic [63:0] er, input logic eix, input logic eiv, input string tag);
    n_chk++;
    if (res !== er || ix !== eix || iv !== eiv) begin
      n_fail++;
      $display("FAIL %s op=%h fmt=%0d mode=%0d dn=%0b: got res=%h ix=%0b iv=%0b, expected res=%h ix=%0b iv=%0b",
               tag, op, fmt, mode, dn, res, ix, iv, er, eix, eiv);
    end
  endtask

  task automatic dir(input logic [1:0] f, input logic [63:0] x, input logic [1:0] m, input logic d,
                     input logic [63:0] er, input logic eix, input logic eiv, input string tag);
    apply(f, x, m, d);
    check(er, eix, eiv, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [17:0] exp_h;
    logic [15:0] hx;
    repeat (3) @(negedge clk);
    check(64'h0, 1'b0, 1'b0, "R11 reset");
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R8 R9 R10: near-exhaustive half sweep
    for (int m = 0; m < 4; m++) begin
      for (int j = 0; j < 32768; j++) begin
        hx = 16'(2 * j + (m & 1));
        apply(2'b00, 64'(hx), 2'(m), j[3]);
        exp_h = ref_half(hx, 2'(m), j[3]);
        check({48'h0, exp_h[15:0]}, exp_h[16], exp_h[17], "R2 R3 R4 half sweep");
      end
    end

    dir(2'b01, 64'h40200000, 2'b00, 0, 64'h40000000, 1, 0, "R3 tie to even down");
    dir(2'b01, 64'h40600000, 2'b00, 0, 64'h40800000, 1, 0, "R3 tie to even up");
    dir(2'b01, 64'h40200000, 2'b01, 0, 64'h40400000, 1, 0, "R2 toward plus");
    dir(2'b01, 64'hC0200000, 2'b10, 0, 64'hC0400000, 1, 0, "R2 toward minus");
    dir(2'b01, 64'hC0200000, 2'b11, 0, 64'hC0000000, 1, 0, "R2 toward zero");
    dir(2'b01, 64'h3F800000, 2'b01, 0, 64'h3F800000, 0, 0, "R4 exact one");
    dir(2'b01, 64'h3F000000, 2'b00, 0, 64'h00000000, 1, 0, "R8 half to zero");
    dir(2'b01, 64'hBF000000, 2'b00, 0, 64'h80000000, 1, 0, "R8 negative zero");
    dir(2'b01, 64'h3F400000, 2'b00, 0, 64'h3F800000, 1, 0, "R8 to one");
    dir(2'b01, 64'hBE800000, 2'b01, 0, 64'h80000000, 1, 0, "R8 neg toward plus");
    dir(2'b01, 64'hBE800000, 2'b10, 0, 64'hBF800000, 1, 0, "R8 neg toward minus");
    dir(2'b01, 64'h00000001, 2'b01, 0, 64'h3F800000, 1, 0, "R8 subnormal");
    dir(2'b01, 64'h4B000001, 2'b01, 0, 64'h4B000001, 0, 0, "R7 integral single");
    dir(2'b01, 64'h80000000, 2'b10, 0, 64'h80000000, 0, 0, "R5 negative zero");
    dir(2'b01, 64'hFF800000, 2'b00, 0, 64'hFF800000, 0, 0, "R6 minus infinity");
    dir(2'b01, 64'h7F800001, 2'b00, 0, 64'h7FC00001, 0, 1, "R9 signalling quieted");
    dir(2'b01, 64'hFFC00005, 2'b00, 0, 64'hFFC00005, 0, 0, "R9 quiet kept");
    dir(2'b01, 64'h7F800001, 2'b00, 1, 64'h7FC00000, 0, 1, "R10 default signalling");
    dir(2'b01, 64'hFFC00005, 2'b00, 1, 64'h7FC00000, 0, 0, "R10 default quiet");
    dir(2'b01, 64'hFFFF_FFFF_3F40_0000, 2'b00, 0, 64'h3F800000, 1, 0, "R1 single upper zero");
    dir(2'b10, 64'h3FF8000000000000, 2'b00, 0, 64'h4000000000000000, 1, 0, "R3 double tie");
    dir(2'b10, 64'h4004000000000000, 2'b00, 0, 64'h4000000000000000, 1, 0, "R3 double even");
    dir(2'b10, 64'h3FF4000000000000, 2'b11, 0, 64'h3FF0000000000000, 1, 0, "R2 double toward zero");
    dir(2'b10, 64'hBFE8000000000000, 2'b01, 0, 64'h8000000000000000, 1, 0, "R8 double neg zero");
    dir(2'b10, 64'h4330000000000001, 2'b00, 0, 64'h4330000000000001, 0, 0, "R7 integral double");
    dir(2'b10, 64'hFFF0000000000000, 2'b01, 0, 64'hFFF0000000000000, 0, 0, "R6 double infinity");
    dir(2'b10, 64'h7FF0000000000001, 2'b00, 1, 64'h7FF8000000000000, 0, 1, "R10 double default");
    dir(2'b11, 64'h3FF8000000000000, 2'b00, 0, 64'h0, 0, 0, "R1 unused format");
    dir(2'b01, 64'h7F800001, 2'b01, 0, 64'h7FC00001, 0, 1, "R12 flags exclusive");
    rst = 1'b1;
    @(negedge clk);
    check(64'h0, 1'b0, 1'b0, "R11 reset clears");
    finish_run();
  end
endmodule